// File: doc/BRIEF.md
# Weighted Threshold Gate with Hysteresis

This block models one state-holding threshold gate for dual-rail, delay-insensitive logic. It takes up to four single-rail inputs, gives each input an integer weight, and compares the weighted count of asserted inputs with a threshold. When the count reaches the threshold, the output goes high. It then stays high until every input has returned to zero.

The gate is modelled as a two-state machine that is updated on a clock. State `ST_EMPTY` drives the output low and state `ST_FULL` drives it high. Transition `FIRE` (`ST_EMPTY` to `ST_FULL`) is taken when the weighted sum reaches the threshold. Transition `DRAIN` (`ST_FULL` to `ST_EMPTY`) is taken when no input is asserted. Transition `FORCE` loads the reset value while the gate reset is active.

Setting the threshold equal to the input count gives a C-element. A threshold of one gives an OR gate. An optional reset flavour forces the output to 0 or to 1 for as long as its reset input is high. A library of gates is built by choosing parameters for each instance.

Top module: `thg_gate`

## Requirements
- R1: In `ST_EMPTY`, with no gate reset, the next state is `ST_FULL` when the weighted sum reaches `THRESH`. The sum adds weight `W<i>` for each asserted `din[i]`. The output shows the new state one clock edge after the inputs are applied.
- R2: In `ST_FULL`, the output stays high while any input is asserted. It goes low one edge after the edge at which all inputs are zero.
- R3: In `ST_EMPTY`, a weighted sum below `THRESH` leaves the output low.
- R4: A four-input gate with `THRESH`=3 and `W0`=2 (`din[0]` is input A, `din[3]` is input D) sets exactly on AB+AC+AD+BCD.
- R5: With `THRESH` equal to `N_IN` and all weights 1, the gate acts as a C-element. It sets only when all inputs are high and clears only when all inputs are low.
- R6: With `THRESH`=1, the output equals the OR of the inputs, delayed by one edge.
- R7: A three-input gate with `THRESH`=2 sets on AB+AC+BC and clears only when A, B and C are all zero.
- R8: While `rst_n` is low, the state is `ST_EMPTY`. The exception is `RST_KIND`=2, where the state is `ST_FULL`.
- R9: With `RST_KIND`=1 (force to 0) or `RST_KIND`=2 (force to 1), a high `gate_rst` drives the output to the forced value in the same cycle. It also loads that value into the state. After release, R1 and R2 apply again.
- R10: With `RST_KIND`=0, `gate_rst` has no effect on the output or the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the state update |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| gate_rst | input | 1 | Level-sensitive gate reset; used only when RST_KIND is not 0 |
| din | input | N_IN | Single-rail inputs; bit 0 is input A |
| dout | output | 1 | Gate output |

## Verification
Every input result is due one clock edge after the inputs are applied. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. The gate-reset result is due in the same cycle, so it is sampled 1 ns after `gate_rst` is raised, before any edge.

Seven gates share one stimulus vector. The bench starts each gate in the cleared state and in the set state, then applies every ordered pair of 4-bit input vectors. After each edge it compares every output with a set/hold model computed in the bench from weights and thresholds.

// File: rtl/thg_pkg.sv
package thg_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } thg_state_t;

    localparam int RK_NONE = 0;
    localparam int RK_ZERO = 1;
    localparam int RK_ONE  = 2;
    localparam int MAX_IN  = 4;
endpackage

// File: rtl/thg_weigh.sv
module thg_weigh #(
    parameter int N_IN   = 3,
    parameter int THRESH = 2,
    parameter int W0     = 1,
    parameter int W1     = 1,
    parameter int W2     = 1,
    parameter int W3     = 1
) (
    input  logic [N_IN-1:0] din,
    output logic            set_hit,
    output logic            any_hi
);
    localparam int WTOT = W0 + W1 + W2 + W3;
    localparam int SW   = $clog2(WTOT + 1) + 1;
    localparam int WV [thg_pkg::MAX_IN] = '{W0, W1, W2, W3};

    logic [SW-1:0] term [N_IN];
    logic [SW-1:0] total;

    for (genvar i = 0; i < N_IN; i++) begin : g_term
        assign term[i] = din[i] ? SW'(WV[i]) : '0;
    end

    always_comb begin
        total = '0;
        for (int i = 0; i < N_IN; i++) total = total + term[i];
    end

    assign set_hit = (total >= SW'(THRESH));
    assign any_hi  = |din;
endmodule

// File: rtl/thg_fsm.sv
module thg_fsm
    import thg_pkg::*;
#(
    parameter int RST_KIND = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frc,
    input  logic set_hit,
    input  logic any_hi,
    output logic dout
);
    localparam thg_state_t PWR_ST = (RST_KIND == RK_ONE) ? ST_FULL : ST_EMPTY;
    localparam logic       RV     = (RST_KIND == RK_ONE);

    thg_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (frc) begin
            state_d = RV ? ST_FULL : ST_EMPTY;              // FORCE
        end else begin
            unique case (state_q)
                ST_EMPTY: state_d = set_hit ? ST_FULL : ST_EMPTY; // FIRE
                ST_FULL:  state_d = any_hi ? ST_FULL : ST_EMPTY;  // DRAIN
                default:  state_d = ST_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_ST;
        else        state_q <= state_d;
    end

    always_comb begin
        dout = frc ? RV : (state_q == ST_FULL);
    end

    p_fire_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY && !frc && set_hit) |=> (state_q == ST_FULL));
    p_stay_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY && !frc && !set_hit) |=> (state_q == ST_EMPTY));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && !frc && any_hi) |=> (state_q == ST_FULL));
    p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!frc && !any_hi) |=> (state_q == ST_EMPTY));
    p_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frc |=> (state_q == (RV ? ST_FULL : ST_EMPTY)));
endmodule

// File: rtl/thg_gate.sv
module thg_gate
    import thg_pkg::*;
#(
    parameter int N_IN     = 3,
    parameter int THRESH   = 2,
    parameter int W0       = 1,
    parameter int W1       = 1,
    parameter int W2       = 1,
    parameter int W3       = 1,
    parameter int RST_KIND = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            gate_rst,
    input  logic [N_IN-1:0] din,
    output logic            dout
);
    logic set_hit, any_hi, frc;

    if (RST_KIND == RK_NONE) begin : g_nofrc
        assign frc = 1'b0;
    end else begin : g_frc
        assign frc = gate_rst;
    end

    thg_weigh #(
        .N_IN(N_IN), .THRESH(THRESH), .W0(W0), .W1(W1), .W2(W2), .W3(W3)
    ) u_weigh (
        .din(din), .set_hit(set_hit), .any_hi(any_hi)
    );

    thg_fsm #(.RST_KIND(RST_KIND)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frc(frc),
        .set_hit(set_hit), .any_hi(any_hi), .dout(dout)
    );

    initial begin
        p_inputs_r1: assert (N_IN >= 1 && N_IN <= MAX_IN && THRESH >= 1);
    end
endmodule

// File: tb/sim_thg_gate.sv
`timescale 1ns/1ps
module sim_thg_gate;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_rst = 1'b0;
    logic [3:0] stim = 4'h0;
    logic [6:0] dq;
    logic [6:0] ex;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    // g0 TH23 (R7), g1 TH34 A weighted 2 (R4), g2 TH22 (R5, R10),
    // g3 TH12 (R6), g4 TH44 (R5), g5 TH22 force-to-one, g6 TH22 force-to-zero (R9)
    thg_gate #(.N_IN(3), .THRESH(2)) u0 (.clk(clk), .rst_n(rst_n), .gate_rst(gate_rst), .din(stim[2:0]), .dout(dq[0]));
    thg_gate #(.N_IN(4), .THRESH(3), .W0(2)) u1 (.clk(clk), .rst_n(rst_n), .gate_rst(gate_rst), .din(stim), .dout(dq[1]));
    thg_gate #(.N_IN(2), .THRESH(2)) u2 (.clk(clk), .rst_n(rst_n), .gate_rst(gate_rst), .din(stim[1:0]), .dout(dq[2]));
    thg_gate #(.N_IN(2), .THRESH(1)) u3 (.clk(clk), .rst_n(rst_n), .gate_rst(gate_rst), .din(stim[1:0]), .dout(dq[3]));
    thg_gate #(.N_IN(4), .THRESH(4)) u4 (.clk(clk), .rst_n(rst_n), .gate_rst(gate_rst), .din(stim), .dout(dq[4]));
    thg_gate #(.N_IN(2), .THRESH(2), .RST_KIND(2)) u5 (.clk(clk), .rst_n(rst_n), .gate_rst(gate_rst), .din(stim[1:0]), .dout(dq[5]));
    thg_gate #(.N_IN(2), .THRESH(2), .RST_KIND(1)) u6 (.clk(clk), .rst_n(rst_n), .gate_rst(gate_rst), .din(stim[1:0]), .dout(dq[6]));

    function automatic int g_n(int k);
        case (k)
            0: return 3;
            1: return 4;
            4: return 4;
            default: return 2;
        endcase
    endfunction

    function automatic int g_m(int k);
        case (k)
            0: return 2;
            1: return 3;
            3: return 1;
            4: return 4;
            default: return 2;
        endcase
    endfunction

    function automatic logic ref_next(int k, logic [3:0] v, logic q, logic r);
        int s = 0;
        logic any = 1'b0;
        for (int i = 0; i < g_n(k); i++) begin
            if (v[i]) begin
                s = s + ((k == 1 && i == 0) ? 2 : 1);
                any = 1'b1;
            end
        end
        if (r && k == 5) return 1'b1;
        if (r && k == 6) return 1'b0;
        return (s >= g_m(k)) || (q && any);
    endfunction

    function automatic string tag(int k);
        case (k)
            0: return "R7";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R5";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(int k, logic exp_v, string req);
        n_cmp++;
        if (dq[k] !== exp_v) begin
            n_bad++;
            $display("FAIL %s gate%0d stim=%b got=%b exp=%b", req, k, stim, dq[k], exp_v);
        end
    endtask

    task automatic step(logic [3:0] v, logic r);
        @(negedge clk);
        stim = v;
        gate_rst = r;
        @(posedge clk);
        for (int k = 0; k < 7; k++) ex[k] = ref_next(k, v, ex[k], r);
        #1;
        for (int k = 0; k < 7; k++) chk(k, ex[k], tag(k));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        for (int k = 0; k < 7; k++) chk(k, (k == 5), "R8");
        ex = 7'b0100000;
        @(negedge clk);
        rst_n = 1'b1;

        // R3: input A alone on the weighted gate stays below threshold
        step(4'h0, 1'b0);
        step(4'h1, 1'b0);
        chk(1, 1'b0, "R3");
        // R2: TH23 holds on a single input, then clears on all-zero
        step(4'h3, 1'b0);
        chk(0, 1'b1, "R2");
        step(4'h1, 1'b0);
        chk(0, 1'b1, "R2");
        step(4'h0, 1'b0);
        chk(0, 1'b0, "R2");

        // full sweep of two-vector sequences from both states (R1)
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) begin
                    step(s ? 4'hF : 4'h0, 1'b0);
                    step(4'(a), 1'b0);
                    step(4'(b), 1'b0);
                end

        // R9 / R10: gate reset
        step(4'h3, 1'b0);
        @(negedge clk);
        gate_rst = 1'b1;
        #1;
        chk(5, 1'b1, "R9");
        chk(6, 1'b0, "R9");
        chk(2, 1'b1, "R10");
        step(4'h3, 1'b1);
        chk(2, 1'b1, "R10");
        step(4'h3, 1'b0);
        chk(6, 1'b1, "R9");
        step(4'h0, 1'b1);
        step(4'h1, 1'b0);
        chk(5, 1'b1, "R9");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule